// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the operating state of a DRAM controller and reports it as a 3-bit status code. Software writes a 3-bit state-change command. A legal command never moves the controller straight to its target state. It first enters a matching request state, which stays visible on the status output for a fixed handshake time (`HS_CYC` cycles). After that time the target state is reached. The handshake time stands in for the acknowledgements that the PHY and the refresh logic would return.

A separate power-up sequencer starts when its start bit is pulsed and raises a sticky done flag after `PWRUP_CYC` cycles. The state machine ignores every command until that flag is set. When the hardware low-power enable is set, the controller can drop from access into low power by itself while an idle hint is asserted. The only way out of low power is a wakeup, which returns to access. Configuration can be reached from there by a second command.

Top module: `mc_opstate_ctrl`

## Requirements
- R1: After reset the status is init-memory (code 0) and the power-up done flag is 0.
- R2: A start pulse while the sequencer is neither running nor done sets the done flag exactly `PWRUP_CYC` cycles after the edge that samples it. The flag then stays 1 until reset. A start pulse while the sequence is already running, or after it has completed, changes nothing.
- R3: While the done flag is 0, every command is ignored and the status stays at init-memory (0).
- R4: A config command (code 1) in init-memory (0) or access (3) shows config-request (2) for `HS_CYC` cycles, then config (1).
- R5: A go command (code 2) in config (1) shows access-request (4) for `HS_CYC` cycles, then access (3).
- R6: A sleep command (code 3) in access (3) shows low-power-entry-request (6) for `HS_CYC` cycles, then low-power (5).
- R7: A wakeup command (code 4) in low-power (5) shows low-power-exit-request (7) for `HS_CYC` cycles, then access (3). A config command in low-power is ignored.
- R8: The following commands leave the status unchanged: any command during a request state (2, 4, 6, 7), the init command (code 0), codes 5 to 7, and any command that is not legal in the current state.
- R9: In access, with the hardware low-power enable at 1, an idle hint moves to low-power-entry-request (6) as a sleep would. With the enable at 0 the idle hint has no effect. A legal command in the same cycle takes precedence over the idle hint.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Qualifies `cmd_code` for one cycle |
| cmd_code | input | 3 | State-change command: 0 init, 1 config, 2 go, 3 sleep, 4 wakeup |
| pwrup_start | input | 1 | Power-up start pulse |
| hw_lp_en | input | 1 | Hardware low-power enable |
| idle_hint | input | 1 | Controller idle indication used for automatic low-power entry |
| stat_code | output | 3 | Current operating or request state |
| pwrup_done | output | 1 | Power-up sequence complete (sticky) |

## Verification
In the access state, a software command and the automatic low-power trigger can arrive in the same cycle. The bench drives a config command together with an asserted idle hint and low-power enable. It requires config-request (2), not entry-request (6), on the next sample. Random stimulus raises `idle_hint`, `hw_lp_en` and `cmd_valid` independently, so this collision also occurs repeatedly with every command code. A reference model in the bench, which gives commands priority, judges each of those cycles.

// File: rtl/mc_opstate_pkg.sv
package mc_opstate_pkg;

  typedef enum logic [2:0] {
    ST_INIT_MEM     = 3'd0,
    ST_CONFIG       = 3'd1,
    ST_CFG_REQ      = 3'd2,
    ST_ACCESS       = 3'd3,
    ST_ACC_REQ      = 3'd4,
    ST_LOW_PWR      = 3'd5,
    ST_LP_ENTRY_REQ = 3'd6,
    ST_LP_EXIT_REQ  = 3'd7
  } opstate_e;

  localparam logic [2:0] CMD_INIT  = 3'd0;
  localparam logic [2:0] CMD_CFG   = 3'd1;
  localparam logic [2:0] CMD_GO    = 3'd2;
  localparam logic [2:0] CMD_SLEEP = 3'd3;
  localparam logic [2:0] CMD_WAKE  = 3'd4;

  // True for the transitional states that wait out the handshake.
  function automatic logic is_req_state(opstate_e s);
    return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
           (s == ST_LP_ENTRY_REQ) || (s == ST_LP_EXIT_REQ);
  endfunction

  // Request state entered for a command; returns s itself when illegal.
  function automatic opstate_e req_for(opstate_e s, logic [2:0] cmd);
    opstate_e r;
    r = s;
    case (s)
      ST_INIT_MEM: if (cmd == CMD_CFG) r = ST_CFG_REQ;
      ST_ACCESS: begin
        if (cmd == CMD_CFG)   r = ST_CFG_REQ;
        if (cmd == CMD_SLEEP) r = ST_LP_ENTRY_REQ;
      end
      ST_CONFIG:  if (cmd == CMD_GO)   r = ST_ACC_REQ;
      ST_LOW_PWR: if (cmd == CMD_WAKE) r = ST_LP_EXIT_REQ;
      default: r = s;
    endcase
    return r;
  endfunction

  // Stable state reached when a request state's handshake completes.
  function automatic opstate_e req_target(opstate_e s);
    case (s)
      ST_CFG_REQ:      return ST_CONFIG;
      ST_ACC_REQ:      return ST_ACCESS;
      ST_LP_ENTRY_REQ: return ST_LOW_PWR;
      ST_LP_EXIT_REQ:  return ST_ACCESS;
      default:         return s;
    endcase
  endfunction

endpackage

// File: rtl/mc_cycle_timer.sv
module mc_cycle_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic expire
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CW-1:0] LOADV = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= LOADV;
    end else if (expire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // A running count never exceeds its load value (supports R2/R4 timing).
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LOADV));
  // Expiry ends the run on the next cycle unless reloaded.
  p_expire_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !busy);
endmodule

// File: rtl/mc_pwrup_seq.sv
module mc_pwrup_seq #(
  parameter int PWRUP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  logic tmr_busy, tmr_expire, launch;

  assign launch = start && !tmr_busy && !done;

  mc_cycle_timer #(.CYC(PWRUP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .busy(tmr_busy), .expire(tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done <= 1'b0;
    else if (tmr_expire) done <= 1'b1;
  end

  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tmr_busy));
endmodule

// File: rtl/mc_opstate_fsm.sv
module mc_opstate_fsm
  import mc_opstate_pkg::*;
#(
  parameter int HS_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       pwr_ok,
  input  logic       hw_lp_en,
  input  logic       idle_hint,
  output opstate_e   state
);
  opstate_e cmd_req;
  logic     cmd_take, auto_lp, hs_load, hs_busy, hs_expire;

  assign cmd_req  = req_for(state, cmd_code);
  assign cmd_take = pwr_ok && cmd_valid && (cmd_req != state);
  assign auto_lp  = pwr_ok && hw_lp_en && idle_hint &&
                    (state == ST_ACCESS) && !cmd_take;
  assign hs_load  = cmd_take || auto_lp;

  mc_cycle_timer #(.CYC(HS_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n), .load(hs_load),
    .busy(hs_busy), .expire(hs_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state <= ST_INIT_MEM;
    else if (cmd_take)   state <= cmd_req;
    else if (auto_lp)    state <= ST_LP_ENTRY_REQ;
    else if (hs_expire)  state <= req_target(state);
  end

  p_hold_until_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (state == ST_INIT_MEM));
  p_config_via_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONFIG && $past(state) != ST_CONFIG) |-> $past(state) == ST_CFG_REQ);
  p_access_via_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACCESS && $past(state) != ST_ACCESS) |->
      ($past(state) == ST_ACC_REQ || $past(state) == ST_LP_EXIT_REQ));
  p_lp_via_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOW_PWR && $past(state) != ST_LOW_PWR) |-> $past(state) == ST_LP_ENTRY_REQ);
  p_lp_exit_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_LOW_PWR && state != ST_LOW_PWR) |-> state == ST_LP_EXIT_REQ);
  p_busy_in_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hs_busy |-> is_req_state(state));
  p_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_req_state(state) && !hs_expire) |=> $stable(state));
endmodule

// File: rtl/mc_opstate_ctrl.sv
module mc_opstate_ctrl
  import mc_opstate_pkg::*;
#(
  parameter int HS_CYC    = 4,
  parameter int PWRUP_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       pwrup_start,
  input  logic       hw_lp_en,
  input  logic       idle_hint,
  output logic [2:0] stat_code,
  output logic       pwrup_done
);
  opstate_e cur_state;

  mc_pwrup_seq #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .start(pwrup_start), .done(pwrup_done)
  );

  mc_opstate_fsm #(.HS_CYC(HS_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pwr_ok(pwrup_done), .hw_lp_en(hw_lp_en), .idle_hint(idle_hint),
    .state(cur_state)
  );

  assign stat_code = cur_state;

  p_auto_lp_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_code) == 3'd3 && stat_code == 3'd6 && !$past(hw_lp_en)) |->
      ($past(cmd_valid) && $past(cmd_code) == 3'd3));
endmodule

// File: tb/mc_opstate_ctrl_test.sv
module mc_opstate_ctrl_test;
  localparam int HS = 4;
  localparam int PW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, pwrup_start = 1'b0, hw_lp_en = 1'b0, idle_hint = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [2:0] stat_code;
  logic pwrup_done;

  int checks = 0, failures = 0;

  // bench reference model
  int m_state = 0, m_hleft = 0, m_pleft = 0;
  bit m_done = 0, m_pbusy = 0;

  always #5 clk = ~clk;

  mc_opstate_ctrl #(.HS_CYC(HS), .PWRUP_CYC(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pwrup_start(pwrup_start), .hw_lp_en(hw_lp_en), .idle_hint(idle_hint),
    .stat_code(stat_code), .pwrup_done(pwrup_done)
  );

  // Request state a command opens, or -1 if the command does nothing.
  function automatic int model_cmd(int st, int c);
    if (c == 1 && (st == 0 || st == 3)) return 2;
    if (c == 2 && st == 1) return 4;
    if (c == 3 && st == 3) return 6;
    if (c == 4 && st == 5) return 7;
    return -1;
  endfunction

  function automatic int model_goal(int st);
    case (st)
      2: return 1;
      4: return 3;
      6: return 5;
      7: return 3;
      default: return st;
    endcase
  endfunction

  function automatic string tag_of(int st);
    case (st)
      0: return "R3";
      1, 2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit cv, int c, bit ps, bit en, bit idl, string tag);
    int nxt;
    bit was_done;
    cmd_valid = cv; cmd_code = 3'(c); pwrup_start = ps;
    hw_lp_en = en; idle_hint = idl;
    was_done = m_done;
    // state model (uses the done flag as seen before this edge)
    nxt = (was_done && cv) ? model_cmd(m_state, c) : -1;
    if (nxt < 0 && was_done && en && idl && m_state == 3) nxt = 6;
    if (nxt >= 0) begin
      m_state = nxt; m_hleft = HS;
    end else if (m_hleft > 0) begin
      m_hleft--;
      if (m_hleft == 0) m_state = model_goal(m_state);
    end
    // power-up model
    if (m_pbusy) begin
      m_pleft--;
      if (m_pleft == 0) begin m_done = 1; m_pbusy = 0; end
    end else if (ps && !m_done) begin
      m_pbusy = 1; m_pleft = PW;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag == "" ? tag_of(m_state) : tag, int'(stat_code), m_state);
    check("R2", int'(pwrup_done), int'(m_done));
  endtask

  task automatic idle_n(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(stat_code), 0);
    check("R1", int'(pwrup_done), 0);

    // R3: commands before power-up done are ignored
    step(1, 1, 0, 1, 1, "R3");
    step(1, 2, 0, 0, 0, "R3");

    // R2: start, restart mid-run ignored, config still ignored while running
    step(0, 0, 1, 0, 0, "R2");
    idle_n(5, "R2");
    step(0, 0, 1, 0, 0, "R2");
    step(1, 1, 0, 0, 0, "R3");
    idle_n(PW, "R2");
    step(0, 0, 1, 0, 0, "R2");   // start after done: no effect

    // R4 from init-memory
    step(1, 1, 0, 0, 0, "R4");
    step(1, 2, 0, 0, 0, "R8");   // go during request ignored
    idle_n(HS, "R4");
    // R8: init command and codes 5..7 in config are ignored
    step(1, 0, 0, 0, 0, "R8");
    step(1, 6, 0, 0, 0, "R8");
    step(1, 3, 0, 0, 0, "R8");
    // R5
    step(1, 2, 0, 0, 0, "R5");
    idle_n(HS, "R5");
    // R9 priority: config and idle hint together
    step(1, 1, 0, 1, 1, "R9");
    idle_n(HS, "R4");
    step(1, 2, 0, 0, 0, "R5");
    idle_n(HS, "R5");
    // R9: enable off means idle has no effect
    step(0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 1, "R9");
    // R9: automatic entry
    step(0, 0, 0, 1, 1, "R9");
    idle_n(HS, "R6");
    // R7: config in low power ignored, wakeup returns to access
    step(1, 1, 0, 0, 0, "R7");
    step(1, 4, 0, 0, 0, "R7");
    step(1, 1, 0, 0, 0, "R8");
    idle_n(HS, "R7");
    // R6: sleep command
    step(1, 3, 0, 0, 0, "R6");
    idle_n(HS, "R6");
    step(1, 4, 0, 0, 0, "R7");
    idle_n(HS, "R7");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      bit cv, ps, en, idl;
      int c;
      cv  = ($urandom % 2) == 0;
      c   = $urandom % 8;
      ps  = ($urandom % 16) == 0;
      en  = ($urandom % 2) == 0;
      idl = ($urandom % 5) == 0;
      step(cv, c, ps, en, idl, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule